// File: doc/BRIEF.md
# Configurable UART Serial Transmitter

This block turns bytes written into a one-entry holding register into asynchronous serial frames on a single output pin. The frame format is chosen at run time: the character can be 5 to 8 bits long, and a parity bit can be added as odd, even or a fixed level. The frame ends with one stop bit, one and a half or two. A break control can pull the line low at any moment, whatever the transmitter is doing.

Bit timing comes from a 16-bit divisor, given as a low byte and a high byte. It divides the block clock down to a tick at sixteen times the bit rate, and every serial bit lasts sixteen of these ticks. The line settings are captured when a frame starts, so software can change them while a character is on the wire without damaging it. An empty flag tells the writer when the line has gone idle with nothing left to send.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, `tx_out` is 1 (idle mark) and `tx_empty` is 1.
- R2: A frame is a start bit at 0, then the data bits least significant bit first. `wlen_sel` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8.
- R3: When `par_en` is 1, one parity bit follows the data bits. With `par_even`=1 the data bits plus the parity bit hold an even number of ones. With `par_even`=0 they hold an odd number.
- R4: When `par_en` and `par_stick` are both 1, the parity bit is fixed: 0 when `par_even`=1 and 1 when `par_even`=0.
- R5: With `stop_one`=1 the frame ends with one stop bit at 1. With `stop_one`=0 it ends with two stop bits, or one and a half when the word length is 5.
- R6: The divisor is {`div_hi`,`div_lo`}. Each bit lasts 16 ticks and each tick lasts divisor clock cycles. A divisor of 1 gives one tick every clock cycle.
- R7: A divisor of 0 stops the tick, which freezes a frame in progress. Once a nonzero divisor is loaded, the frame continues.
- R8: In every clock cycle after one in which `brk_force` was 1, `tx_out` is 0. When `brk_force` returns to 0, the line goes back to the level of the frame in progress.
- R9: `tx_empty` is 0 in the cycle after any write. It returns to 1 within two clock cycles after the last stop bit ends, provided no character is waiting. While `tx_empty` is 1 the line is at 1, unless break was active in the previous cycle.
- R10: The word length, parity and stop settings are sampled when a frame starts. Changing them during the frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock and baud reference |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to transmit |
| wlen_sel | input | 2 | Word length code |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| par_stick | input | 1 | Forces the parity bit to a fixed level |
| stop_one | input | 1 | 1 gives one stop bit; 0 gives the long stop |
| brk_force | input | 1 | Holds the serial line low |
| div_lo | input | 8 | Divisor low byte |
| div_hi | input | 8 | Divisor high byte |
| tx_empty | output | 1 | No frame active and no character waiting |
| tx_out | output | 1 | Serial output |

## Verification
The bench sends frames in every word length and with each parity mode, and checks every bit at the middle of its cell. A design that sent the most significant bit first, or masked the word wrongly, would show wrong data bits. A design that computed parity over unmasked bits or inverted the stick level would show a wrong parity bit. Each stop length is measured as the spacing between two back-to-back start edges, so a half-bit or full-bit error in the stop counter shows up as a shifted second frame. Further directed cases cover these points:
- a divisor of zero, which must freeze the line in the start bit rather than run free;
- a divisor of one, and a divisor built only from the high byte;
- break raised in the middle of a frame;
- a frame format rewritten while a frame is running, which must not cut the character short.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef enum logic [1:0] {
    STOP_ONE  = 2'd0,
    STOP_HALF = 2'd1,
    STOP_TWO  = 2'd2
  } stop_len_e;

  typedef struct packed {
    logic [2:0] last_bit;
    logic       has_par;
    logic       par_bit;
    stop_len_e  stop_len;
  } frame_cfg_t;

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (divisor == '0) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= divisor - 1'b1) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '1;
      full_q <= 1'b0;
    end else begin
      if (take) full_q <= 1'b0;
      if (wr_valid) begin
        data_q <= wr_data;
        full_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_valid,
  input  logic       hold_full,
  input  logic [7:0] hold_data,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       stop_one,
  input  logic       brk,
  output logic       take,
  output logic       tx_out,
  output logic       tx_empty
);

  localparam int CNT_W = $clog2(2 * OVS);
  localparam logic [CNT_W-1:0] BIT_END    = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] HALF15_END = CNT_W'(OVS + OVS / 2 - 1);
  localparam logic [CNT_W-1:0] TWO_END    = CNT_W'(2 * OVS - 1);

  tx_state_e        state_q;
  logic [CNT_W-1:0] tcnt_q;
  logic [2:0]       bidx_q;
  logic [7:0]       shreg_q;
  frame_cfg_t       cfg_q;
  frame_cfg_t       cfg_new;
  logic [7:0]       mask;
  logic [7:0]       masked;
  logic             line_lvl;
  logic             cell_done;
  logic [CNT_W-1:0] stop_end;

  // frame settings captured at the start edge
  always_comb begin
    mask             = 8'hFF >> (2'd3 - wlen);
    masked           = hold_data & mask;
    cfg_new.last_bit = 3'd4 + {1'b0, wlen};
    cfg_new.has_par  = par_en;
    if (par_stick)     cfg_new.par_bit = ~par_even;
    else if (par_even) cfg_new.par_bit = ^masked;
    else               cfg_new.par_bit = ~(^masked);
    if (stop_one)          cfg_new.stop_len = STOP_ONE;
    else if (wlen == 2'd0) cfg_new.stop_len = STOP_HALF;
    else                   cfg_new.stop_len = STOP_TWO;
  end

  always_comb begin
    case (cfg_q.stop_len)
      STOP_HALF: stop_end = HALF15_END;
      STOP_TWO:  stop_end = TWO_END;
      default:   stop_end = BIT_END;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_START: line_lvl = 1'b0;
      ST_DATA:  line_lvl = shreg_q[0];
      ST_PAR:   line_lvl = cfg_q.par_bit;
      default:  line_lvl = 1'b1;
    endcase
  end

  assign take      = (state_q == ST_IDLE) && hold_full;
  assign cell_done = tick && (tcnt_q == BIT_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      tcnt_q   <= '0;
      bidx_q   <= '0;
      shreg_q  <= '0;
      cfg_q    <= '0;
      tx_out   <= 1'b1;
      tx_empty <= 1'b1;
    end else begin
      tx_out   <= brk ? 1'b0 : line_lvl;
      tx_empty <= (state_q == ST_IDLE) && !hold_full && !wr_valid;
      case (state_q)
        ST_IDLE: begin
          if (take) begin
            state_q <= ST_START;
            tcnt_q  <= '0;
            shreg_q <= hold_data;
            cfg_q   <= cfg_new;
          end
        end
        ST_START: begin
          if (cell_done) begin
            state_q <= ST_DATA;
            tcnt_q  <= '0;
            bidx_q  <= '0;
          end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cell_done) begin
            tcnt_q <= '0;
            if (bidx_q == cfg_q.last_bit) begin
              state_q <= cfg_q.has_par ? ST_PAR : ST_STOP;
            end else begin
              bidx_q  <= bidx_q + 1'b1;
              shreg_q <= {1'b0, shreg_q[7:1]};
            end
          end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (cell_done) begin
            state_q <= ST_STOP;
            tcnt_q  <= '0;
          end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (tick && (tcnt_q == stop_end)) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
          end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          tcnt_q  <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int OVS    = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        wlen_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              stop_one,
  input  logic              brk_force,
  input  logic [BYTE_W-1:0] div_lo,
  input  logic [BYTE_W-1:0] div_hi,
  output logic              tx_empty,
  output logic              tx_out
);

  localparam int DIV_W = 2 * BYTE_W;

  logic [DIV_W-1:0]  divisor;
  logic              tick;
  logic              take;
  logic              hold_full;
  logic [BYTE_W-1:0] hold_data;

  assign divisor = {div_hi, div_lo};

  uart_baud_gen #(.DIV_W(DIV_W)) baud_i (
    .clk     (clk),
    .rst     (rst),
    .divisor (divisor),
    .tick    (tick)
  );

  uart_tx_hold #(.DATA_W(BYTE_W)) hold_i (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .take     (take),
    .data_q   (hold_data),
    .full_q   (hold_full)
  );

  uart_tx_seq #(.OVS(OVS)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .wr_valid  (wr_valid),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .wlen      (wlen_sel),
    .par_en    (par_en),
    .par_even  (par_even),
    .par_stick (par_stick),
    .stop_one  (stop_one),
    .brk       (brk_force),
    .take      (take),
    .tx_out    (tx_out),
    .tx_empty  (tx_empty)
  );

endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk,
  input logic rst,
  input logic wr_valid,
  input logic brk_force,
  input logic tx_out,
  input logic tx_empty
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx_out && tx_empty)); // R1

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(brk_force)) |-> !tx_out); // R8

  AST_WRITE_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_valid)) |-> !tx_empty); // R9

  AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && !$past(rst) && !$past(brk_force)) |-> tx_out); // R9

endmodule

bind uart_tx_core uart_tx_chk chk_i (.*);

// File: tb/uart_tx_core_tb_top.sv
module uart_tx_core_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] wlen_sel = 2'd3;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       par_stick = 1'b0;
  logic       stop_one = 1'b1;
  logic       brk_force = 1'b0;
  logic [7:0] div_lo = 8'd2;
  logic [7:0] div_hi = 8'd0;
  logic       tx_empty;
  logic       tx_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_core dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wlen_sel(wlen_sel), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .stop_one(stop_one), .brk_force(brk_force),
    .div_lo(div_lo), .div_hi(div_hi), .tx_empty(tx_empty), .tx_out(tx_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_div(input int d);
    @(negedge clk);
    div_lo = d[7:0];
    div_hi = d[15:8];
  endtask

  task automatic set_fmt(input logic [1:0] wl, input logic pe, input logic ev,
                         input logic st, input logic s1);
    @(negedge clk);
    wlen_sel = wl; par_en = pe; par_even = ev; par_stick = st; stop_one = s1;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_level(input logic lvl, input int lim, output bit found);
    found = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (tx_out == lvl) begin
        found = 1'b1;
        break;
      end
    end
  endtask

  task automatic wait_empty(input int lim, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (tx_empty) begin
        seen = 1'b1;
        break;
      end
    end
    check(seen, req, "tx_empty returns after frame", int'(seen), 1);
  endtask

  function automatic logic exp_par(input logic [7:0] d, input logic [1:0] wl,
                                   input logic ev, input logic st);
    logic [7:0] m;
    m = d & (8'hFF >> (2'd3 - wl));
    if (st) return ~ev;
    return ev ? ^m : ~(^m);
  endfunction

  // full frame, sampled at the middle of every bit cell
  task automatic t_frame(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                         input logic ev, input logic st, input int dv, input string ptag);
    bit   found;
    int   per = 16 * dv;
    int   nb  = 5 + int'(wl);
    set_div(dv);
    set_fmt(wl, pe, ev, st, 1'b1);
    send(d);
    wait_level(1'b0, 4 * per, found);
    check(found, "R2", "start edge seen", int'(found), 1);
    repeat (per / 2) @(negedge clk);
    check(tx_out == 1'b0, "R2", "start bit", int'(tx_out), 0);
    for (int k = 0; k < nb; k++) begin
      repeat (per) @(negedge clk);
      check(tx_out == d[k], "R2", $sformatf("data bit %0d of %0d", k, nb),
            int'(tx_out), int'(d[k]));
    end
    if (pe) begin
      repeat (per) @(negedge clk);
      check(tx_out == exp_par(d, wl, ev, st), ptag, "parity bit",
            int'(tx_out), int'(exp_par(d, wl, ev, st)));
    end
    repeat (per) @(negedge clk);
    check(tx_out == 1'b1, "R5", "stop bit", int'(tx_out), 1);
    wait_empty(2 * per, "R9");
  endtask

  // start-to-start spacing of two back-to-back 0xFF frames
  task automatic t_stop_len(input logic [1:0] wl, input logic s1, input int halves,
                            input string req);
    bit found;
    int t0, t1, expv, dv;
    dv = 4;
    set_div(dv);
    set_fmt(wl, 1'b0, 1'b0, 1'b0, s1);
    send(8'hFF);
    wait_level(1'b0, 200, found);
    t0 = cyc;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'hFF;
    @(negedge clk);
    wr_valid = 1'b0;
    wait_level(1'b1, 200, found);
    wait_level(1'b0, 2000, found);
    t1 = cyc;
    expv = (1 + 5 + int'(wl)) * 16 * dv + halves * 8 * dv;
    check(found && (t1 - t0 >= expv - dv) && (t1 - t0 <= expv + 3), req,
          "frame spacing in cycles", t1 - t0, expv);
    wait_empty(2000, "R9");
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(tx_out == 1'b1, "R1", "tx_out after reset", int'(tx_out), 1);
    check(tx_empty == 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
  endtask

  task automatic t_empty_on_write;
    set_div(2);
    set_fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'h3C;
    @(negedge clk);
    wr_valid = 1'b0;
    check(tx_empty == 1'b0, "R9", "tx_empty after write", int'(tx_empty), 0);
    repeat (100) @(negedge clk);
    check(tx_empty == 1'b0, "R9", "tx_empty mid frame", int'(tx_empty), 0);
    wait_empty(600, "R9");
    check(tx_out == 1'b1, "R9", "line idle when empty", int'(tx_out), 1);
  endtask

  task automatic t_div_zero;
    set_fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    set_div(0);
    send(8'h55);
    repeat (50) @(negedge clk);
    check(tx_out == 1'b0, "R7", "line frozen in start bit", int'(tx_out), 0);
    repeat (300) @(negedge clk);
    check(tx_out == 1'b0, "R7", "still frozen", int'(tx_out), 0);
    check(tx_empty == 1'b0, "R7", "not empty while frozen", int'(tx_empty), 0);
    set_div(1);
    wait_empty(400, "R7");
  endtask

  task automatic t_break;
    bit found;
    @(negedge clk);
    brk_force = 1'b1;
    @(negedge clk);
    check(tx_out == 1'b0, "R8", "break while idle", int'(tx_out), 0);
    brk_force = 1'b0;
    @(negedge clk);
    check(tx_out == 1'b1, "R8", "idle after break", int'(tx_out), 1);
    set_div(2);
    set_fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    send(8'hFF);
    wait_level(1'b0, 200, found);
    repeat (16 + 3 * 32) @(negedge clk);
    brk_force = 1'b1;
    @(negedge clk);
    check(tx_out == 1'b0, "R8", "break mid frame", int'(tx_out), 0);
    repeat (20) @(negedge clk);
    check(tx_out == 1'b0, "R8", "break held", int'(tx_out), 0);
    brk_force = 1'b0;
    @(negedge clk);
    check(tx_out == 1'b1, "R8", "data level after break", int'(tx_out), 1);
    wait_empty(600, "R9");
  endtask

  task automatic t_cfg_midframe;
    bit found;
    logic [7:0] d = 8'hA5;
    set_div(2);
    set_fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    send(d);
    wait_level(1'b0, 200, found);
    repeat (16) @(negedge clk);
    wlen_sel = 2'd0; par_en = 1'b1; stop_one = 1'b0;
    for (int k = 0; k < 8; k++) begin
      repeat (32) @(negedge clk);
      check(tx_out == d[k], "R10", $sformatf("bit %0d after format change", k),
            int'(tx_out), int'(d[k]));
    end
    repeat (32) @(negedge clk);
    check(tx_out == 1'b1, "R10", "stop at original position", int'(tx_out), 1);
    wait_empty(600, "R9");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_empty_on_write();
    t_frame(8'hB4, 2'd3, 1'b0, 1'b0, 1'b0, 2, "R3");
    t_frame(8'h1B, 2'd0, 1'b0, 1'b0, 1'b0, 1, "R3");   // R6 divisor 1
    t_frame(8'h2D, 2'd1, 1'b1, 1'b1, 1'b0, 2, "R3");
    t_frame(8'h6E, 2'd2, 1'b1, 1'b0, 1'b0, 3, "R3");
    t_frame(8'hF7, 2'd3, 1'b1, 1'b1, 1'b0, 2, "R3");
    t_frame(8'hF7, 2'd3, 1'b1, 1'b1, 1'b1, 2, "R4");
    t_frame(8'h01, 2'd0, 1'b1, 1'b0, 1'b1, 2, "R4");
    t_frame(8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 256, "R6"); // R6 high byte only
    t_stop_len(2'd3, 1'b1, 2, "R5");
    t_stop_len(2'd3, 1'b0, 4, "R5");
    t_stop_len(2'd0, 1'b0, 3, "R5");
    t_stop_len(2'd1, 1'b1, 2, "R5");
    t_div_zero();
    t_break();
    t_cfg_midframe();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule